// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the raster timing of a video stream from a pixel clock and a set of programmable timing settings. A horizontal counter walks each line across both the visible and the blanking pixels, and a vertical counter walks the lines of a field. From these two counters the block drives horizontal sync, vertical sync, horizontal blank, vertical blank, an active-video flag, a field identifier and the current pixel and line coordinates. Coordinate (0,0) is the first visible pixel of the first visible line. Line 0 is therefore the top visible line, and the vertical blanking interval sits at the bottom of each field.

The settings are split into a shared part and two per-field banks. The shared part holds the total pixels per line, the visible width and height, and the horizontal sync window. Each bank holds the line count of its field, the pixel positions where vertical blank rises and falls, and the line and pixel of each vertical sync edge. In interlaced mode, even fields use bank 0 and odd fields use bank 1. The two fields may differ in height and in the pixel at which their vertical edges fall. In progressive mode only bank 0 is used.

Software loads the settings through a simple parallel write port. Each write goes to a shadow copy. The whole shadow set becomes live in one step at the end of a frame, so a frame never mixes old and new timing.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel counter steps by one each clock from 0 to HTOTAL-1 and then wraps to 0. The line counter advances on each pixel wrap from 0 to LINES-1 of the current field and then wraps to 0. `pix_x` and `line_y` present the counter pair.
- R2: `hblank` is high exactly when the pixel index is at or above the visible width.
- R3: `hsync` is high exactly when the pixel index is at or above the sync-begin pixel and below the sync-end pixel. Both values come from the shared horizontal sync register.
- R4: Positions are ordered line first, then pixel. `vblank` is high from position (visible height, blank-begin pixel) onward. On the last line of the field it is low again from the blank-end pixel on. Both pixels come from the current field's bank.
- R5: `vsync` is high from position (begin line, begin pixel) up to but not including position (end line, end pixel). All four values come from the current field's bank.
- R6: `active` is high exactly when both `hblank` and `vblank` are low.
- R7: In interlaced mode (mode bit 0 = 1), `field_id` toggles at every line-counter wrap, and the field selects the bank: 0 selects bank 0, 1 selects bank 1. In progressive mode `field_id` returns to 0 at the wrap and bank 0 is used. `field_id` changes only at position (0,0).
- R8: Writes update only shadow settings. The live settings take the whole shadow set on the clock edge where the counters leave the last pixel of a frame. In progressive mode this is every field end. In interlaced mode it is only the end of field 1. A write on that same edge waits for the next frame end.
- R9: All outputs are registered and show the counter position of the previous clock. During reset every output is 0. The first clock after reset shows position (0,0) of field 0. After reset, the shadow and live settings hold the parameter defaults.
- R10: Register map. Each data word is split into a low field (bits CW-1:0) and a high field (bits 2CW-1:CW).
  - Address 0: mode, with the interlace flag in bit 0.
  - Address 1: total pixels per line, in the low field.
  - Address 2: visible width in the low field, visible height in the high field.
  - Address 3: sync-begin pixel in the low field, sync-end pixel in the high field.
  - Addresses 4 to 7: bank 0. Addresses 8 to 11: bank 1. Within a bank, the offsets are:
    - +0: line count, in the low field.
    - +1: blank-begin pixel in the low field, blank-end pixel in the high field.
    - +2: vertical sync begin line in the low field, end line in the high field.
    - +3: vertical sync begin pixel in the low field, end pixel in the high field.
  - Other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 2*CW | Register write data (high field, low field) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| active | output | 1 | Visible pixel flag |
| field_id | output | 1 | Current field, 0 or 1 |
| pix_x | output | CW | Pixel index within the line |
| line_y | output | CW | Line index within the field |

## Verification
Two events can fall on the same cycle: a register write, and the frame-end edge where the shadow set becomes live together with the field toggle and bank swap. The bench keeps its own model of the counter position. It issues a write exactly on the cycle the model marks as frame end, and expects the new value to stay invisible for one more full frame. The bench also places vertical blank and vertical sync edges at mid-line pixels that differ between the two fields. Every output is then compared on every cycle against a model of the position and settings.

// File: rtl/rtg_pkg.sv
// Shared constants for the raster timing generator: register addresses
// and the layout of the two per-field banks. Assumes a 4-bit address.
package rtg_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_MODE    = 4'd0,
        RA_HTOTAL  = 4'd1,
        RA_VISIBLE = 4'd2,
        RA_HSYNC   = 4'd3
    } shared_addr_e;

    // Per-field banks start at BANK_BASE, one bank every BANK_STRIDE words.
    localparam int BANK_BASE   = 4;
    localparam int BANK_STRIDE = 4;
    localparam int OFF_LINES   = 0;
    localparam int OFF_VBL_PIX = 1;
    localparam int OFF_VS_LINE = 2;
    localparam int OFF_VS_PIX  = 3;
    localparam int NUM_BANKS   = 2;

endpackage

// File: rtl/rtg_regs.sv
// Shadow and live timing settings. Writes land in the shadow set; the
// whole set is copied to the live set on the 'apply' pulse (frame end).
// Assumes apply comes from the counter and is a single-cycle pulse.
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int CW              = 12,
    parameter int DEF_HTOTAL      = 12,
    parameter int DEF_HVIS        = 8,
    parameter int DEF_VVIS        = 4,
    parameter int DEF_HS_BEG      = 9,
    parameter int DEF_HS_END      = 11,
    parameter int DEF_LINES       = 7,
    parameter int DEF_VBL_BEG     = 8,
    parameter int DEF_VBL_END     = 9,
    parameter int DEF_VS_LINE_BEG = 5,
    parameter int DEF_VS_LINE_END = 6,
    parameter int DEF_VS_PIX_BEG  = 2,
    parameter int DEF_VS_PIX_END  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [2*CW-1:0]               wr_data,
    input  logic                          apply,
    output logic                          live_il,
    output logic [CW-1:0]                 live_htotal,
    output logic [CW-1:0]                 live_hvis,
    output logic [CW-1:0]                 live_vvis,
    output logic [CW-1:0]                 live_hs_beg,
    output logic [CW-1:0]                 live_hs_end,
    output logic [NUM_BANKS-1:0][CW-1:0]  live_lines,
    output logic [NUM_BANKS-1:0][CW-1:0]  live_vbl_beg,
    output logic [NUM_BANKS-1:0][CW-1:0]  live_vbl_end,
    output logic [NUM_BANKS-1:0][CW-1:0]  live_vs_lbeg,
    output logic [NUM_BANKS-1:0][CW-1:0]  live_vs_lend,
    output logic [NUM_BANKS-1:0][CW-1:0]  live_vs_pbeg,
    output logic [NUM_BANKS-1:0][CW-1:0]  live_vs_pend
);

    logic [CW-1:0] lo_f, hi_f;
    assign lo_f = wr_data[CW-1:0];
    assign hi_f = wr_data[2*CW-1:CW];

    logic          sh_il;
    logic [CW-1:0] sh_htotal, sh_hvis, sh_vvis, sh_hs_beg, sh_hs_end;

    // Shadow copy of the shared settings, written by the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_il     <= 1'b0;
            sh_htotal <= CW'(DEF_HTOTAL);
            sh_hvis   <= CW'(DEF_HVIS);
            sh_vvis   <= CW'(DEF_VVIS);
            sh_hs_beg <= CW'(DEF_HS_BEG);
            sh_hs_end <= CW'(DEF_HS_END);
        end else if (wr_en) begin
            case (wr_addr)
                RA_MODE:    sh_il     <= wr_data[0];
                RA_HTOTAL:  sh_htotal <= lo_f;
                RA_VISIBLE: begin sh_hvis <= lo_f; sh_vvis <= hi_f; end
                RA_HSYNC:   begin sh_hs_beg <= lo_f; sh_hs_end <= hi_f; end
                default: ;
            endcase
        end
    end

    // Live copy of the shared settings, loaded at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_il     <= 1'b0;
            live_htotal <= CW'(DEF_HTOTAL);
            live_hvis   <= CW'(DEF_HVIS);
            live_vvis   <= CW'(DEF_VVIS);
            live_hs_beg <= CW'(DEF_HS_BEG);
            live_hs_end <= CW'(DEF_HS_END);
        end else if (apply) begin
            live_il     <= sh_il;
            live_htotal <= sh_htotal;
            live_hvis   <= sh_hvis;
            live_vvis   <= sh_vvis;
            live_hs_beg <= sh_hs_beg;
            live_hs_end <= sh_hs_end;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(BANK_BASE + b * BANK_STRIDE);
        logic [CW-1:0] sh_lines, sh_vbl_beg, sh_vbl_end;
        logic [CW-1:0] sh_vs_lbeg, sh_vs_lend, sh_vs_pbeg, sh_vs_pend;

        // Shadow copy of this field's bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_lines   <= CW'(DEF_LINES);
                sh_vbl_beg <= CW'(DEF_VBL_BEG);
                sh_vbl_end <= CW'(DEF_VBL_END);
                sh_vs_lbeg <= CW'(DEF_VS_LINE_BEG);
                sh_vs_lend <= CW'(DEF_VS_LINE_END);
                sh_vs_pbeg <= CW'(DEF_VS_PIX_BEG);
                sh_vs_pend <= CW'(DEF_VS_PIX_END);
            end else if (wr_en) begin
                if (wr_addr == A_BASE + ADDR_W'(OFF_LINES))
                    sh_lines <= lo_f;
                if (wr_addr == A_BASE + ADDR_W'(OFF_VBL_PIX)) begin
                    sh_vbl_beg <= lo_f;
                    sh_vbl_end <= hi_f;
                end
                if (wr_addr == A_BASE + ADDR_W'(OFF_VS_LINE)) begin
                    sh_vs_lbeg <= lo_f;
                    sh_vs_lend <= hi_f;
                end
                if (wr_addr == A_BASE + ADDR_W'(OFF_VS_PIX)) begin
                    sh_vs_pbeg <= lo_f;
                    sh_vs_pend <= hi_f;
                end
            end
        end

        // Live copy of this field's bank, loaded at frame end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_lines[b]   <= CW'(DEF_LINES);
                live_vbl_beg[b] <= CW'(DEF_VBL_BEG);
                live_vbl_end[b] <= CW'(DEF_VBL_END);
                live_vs_lbeg[b] <= CW'(DEF_VS_LINE_BEG);
                live_vs_lend[b] <= CW'(DEF_VS_LINE_END);
                live_vs_pbeg[b] <= CW'(DEF_VS_PIX_BEG);
                live_vs_pend[b] <= CW'(DEF_VS_PIX_END);
            end else if (apply) begin
                live_lines[b]   <= sh_lines;
                live_vbl_beg[b] <= sh_vbl_beg;
                live_vbl_end[b] <= sh_vbl_end;
                live_vs_lbeg[b] <= sh_vs_lbeg;
                live_vs_lend[b] <= sh_vs_lend;
                live_vs_pbeg[b] <= sh_vs_pbeg;
                live_vs_pend[b] <= sh_vs_pend;
            end
        end
    end

endmodule

// File: rtl/rtg_counter.sv
// Pixel, line and field counters. The pixel counter wraps at the line total;
// the line counter wraps at the current field's line count; the field bit
// toggles at a line wrap in interlaced mode only. Flags the last pixel of a
// frame. Assumes totals of at least 1 that change only at frame end.
module rtg_counter #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          il,
    input  logic [CW-1:0] htotal,
    input  logic [CW-1:0] lines,
    output logic [CW-1:0] cnt_h,
    output logic [CW-1:0] cnt_v,
    output logic          fld,
    output logic          frame_end
);

    logic h_last, v_last;
    assign h_last = (cnt_h == htotal - CW'(1));
    assign v_last = (cnt_v == lines - CW'(1));

    // Frame end: last pixel of the field that closes a frame.
    assign frame_end = h_last && v_last && (!il || fld);

    // Advance the raster position by one pixel per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_h <= '0;
            cnt_v <= '0;
            fld   <= 1'b0;
        end else if (h_last) begin
            cnt_h <= '0;
            if (v_last) begin
                cnt_v <= '0;
                fld   <= il ? ~fld : 1'b0;
            end else begin
                cnt_v <= cnt_v + CW'(1);
            end
        end else begin
            cnt_h <= cnt_h + CW'(1);
        end
    end

endmodule

// File: rtl/rtg_decode.sv
// Compares the raster position with the live settings of the current field
// and registers every timing output, so all of them move on the same edge.
// Assumes begin positions precede end positions within a field.
module rtg_decode
    import rtg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CW-1:0]                 cnt_h,
    input  logic [CW-1:0]                 cnt_v,
    input  logic                          fld,
    input  logic [CW-1:0]                 hvis,
    input  logic [CW-1:0]                 vvis,
    input  logic [CW-1:0]                 hs_beg,
    input  logic [CW-1:0]                 hs_end,
    input  logic [NUM_BANKS-1:0][CW-1:0]  lines,
    input  logic [NUM_BANKS-1:0][CW-1:0]  vbl_beg,
    input  logic [NUM_BANKS-1:0][CW-1:0]  vbl_end,
    input  logic [NUM_BANKS-1:0][CW-1:0]  vs_lbeg,
    input  logic [NUM_BANKS-1:0][CW-1:0]  vs_lend,
    input  logic [NUM_BANKS-1:0][CW-1:0]  vs_pbeg,
    input  logic [NUM_BANKS-1:0][CW-1:0]  vs_pend,
    output logic                          hsync,
    output logic                          vsync,
    output logic                          hblank,
    output logic                          vblank,
    output logic                          active,
    output logic                          field_id,
    output logic [CW-1:0]                 pix_x,
    output logic [CW-1:0]                 line_y
);

    // True when (v,h) is at or after (lv,lh), ordering lines before pixels.
    function automatic logic reached(input logic [CW-1:0] v, input logic [CW-1:0] h,
                                     input logic [CW-1:0] lv, input logic [CW-1:0] lh);
        return (v > lv) || ((v == lv) && (h >= lh));
    endfunction

    logic n_hblank, n_hsync, n_vblank, n_vsync, vbl_over;

    // Next values of the timing flags for the current position.
    always_comb begin
        n_hblank = (cnt_h >= hvis);
        n_hsync  = (cnt_h >= hs_beg) && (cnt_h < hs_end);
        vbl_over = (cnt_v == lines[fld] - CW'(1)) && (cnt_h >= vbl_end[fld]);
        n_vblank = reached(cnt_v, cnt_h, vvis, vbl_beg[fld]) && !vbl_over;
        n_vsync  = reached(cnt_v, cnt_h, vs_lbeg[fld], vs_pbeg[fld]) &&
                   !reached(cnt_v, cnt_h, vs_lend[fld], vs_pend[fld]);
    end

    // Output register stage for flags and coordinates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync    <= 1'b0;
            vsync    <= 1'b0;
            hblank   <= 1'b0;
            vblank   <= 1'b0;
            active   <= 1'b0;
            field_id <= 1'b0;
            pix_x    <= '0;
            line_y   <= '0;
        end else begin
            hsync    <= n_hsync;
            vsync    <= n_vsync;
            hblank   <= n_hblank;
            vblank   <= n_vblank;
            active   <= !n_hblank && !n_vblank;
            field_id <= fld;
            pix_x    <= cnt_h;
            line_y   <= cnt_v;
        end
    end

endmodule

// File: rtl/raster_timing_gen.sv
// Top of the raster timing generator: register file, counters and output
// decode. Assumes a valid setting set (visible sizes below totals, sync
// windows inside the field) is present whenever it becomes live.
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int CW              = 12,
    parameter int DEF_HTOTAL      = 12,
    parameter int DEF_HVIS        = 8,
    parameter int DEF_VVIS        = 4,
    parameter int DEF_HS_BEG      = 9,
    parameter int DEF_HS_END      = 11,
    parameter int DEF_LINES       = 7,
    parameter int DEF_VBL_BEG     = 8,
    parameter int DEF_VBL_END     = 9,
    parameter int DEF_VS_LINE_BEG = 5,
    parameter int DEF_VS_LINE_END = 6,
    parameter int DEF_VS_PIX_BEG  = 2,
    parameter int DEF_VS_PIX_END  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [2*CW-1:0]   wr_data,
    output logic              hsync,
    output logic              vsync,
    output logic              hblank,
    output logic              vblank,
    output logic              active,
    output logic              field_id,
    output logic [CW-1:0]     pix_x,
    output logic [CW-1:0]     line_y
);

    logic                          live_il;
    logic [CW-1:0]                 live_htotal, live_hvis, live_vvis;
    logic [CW-1:0]                 live_hs_beg, live_hs_end;
    logic [NUM_BANKS-1:0][CW-1:0]  live_lines, live_vbl_beg, live_vbl_end;
    logic [NUM_BANKS-1:0][CW-1:0]  live_vs_lbeg, live_vs_lend, live_vs_pbeg, live_vs_pend;
    logic [CW-1:0]                 cnt_h, cnt_v, cur_lines;
    logic                          fld, frame_end;

    assign cur_lines = live_lines[fld];

    rtg_regs #(
        .CW(CW), .DEF_HTOTAL(DEF_HTOTAL), .DEF_HVIS(DEF_HVIS), .DEF_VVIS(DEF_VVIS),
        .DEF_HS_BEG(DEF_HS_BEG), .DEF_HS_END(DEF_HS_END), .DEF_LINES(DEF_LINES),
        .DEF_VBL_BEG(DEF_VBL_BEG), .DEF_VBL_END(DEF_VBL_END),
        .DEF_VS_LINE_BEG(DEF_VS_LINE_BEG), .DEF_VS_LINE_END(DEF_VS_LINE_END),
        .DEF_VS_PIX_BEG(DEF_VS_PIX_BEG), .DEF_VS_PIX_END(DEF_VS_PIX_END)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .apply(frame_end), .live_il(live_il), .live_htotal(live_htotal),
        .live_hvis(live_hvis), .live_vvis(live_vvis),
        .live_hs_beg(live_hs_beg), .live_hs_end(live_hs_end),
        .live_lines(live_lines), .live_vbl_beg(live_vbl_beg), .live_vbl_end(live_vbl_end),
        .live_vs_lbeg(live_vs_lbeg), .live_vs_lend(live_vs_lend),
        .live_vs_pbeg(live_vs_pbeg), .live_vs_pend(live_vs_pend)
    );

    rtg_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .il(live_il), .htotal(live_htotal), .lines(cur_lines),
        .cnt_h(cnt_h), .cnt_v(cnt_v), .fld(fld), .frame_end(frame_end)
    );

    rtg_decode #(.CW(CW)) u_dec (
        .clk(clk), .rst_n(rst_n), .cnt_h(cnt_h), .cnt_v(cnt_v), .fld(fld),
        .hvis(live_hvis), .vvis(live_vvis), .hs_beg(live_hs_beg), .hs_end(live_hs_end),
        .lines(live_lines), .vbl_beg(live_vbl_beg), .vbl_end(live_vbl_end),
        .vs_lbeg(live_vs_lbeg), .vs_lend(live_vs_lend),
        .vs_pbeg(live_vs_pbeg), .vs_pend(live_vs_pend),
        .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
        .active(active), .field_id(field_id), .pix_x(pix_x), .line_y(line_y)
    );

endmodule

// File: rtl/rtg_checker.sv
// Property checker for the raster timing generator, bound into the top.
// Relates counter state, live settings and registered outputs over time.
module rtg_checker #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt_h,
    input logic [CW-1:0] cnt_v,
    input logic [CW-1:0] htotal,
    input logic [CW-1:0] hvis,
    input logic [CW-1:0] pix_x,
    input logic [CW-1:0] line_y,
    input logic          hblank,
    input logic          vblank,
    input logic          active,
    input logic          field_id
);

    logic armed;

    // Set once the output stage has captured a post-reset position.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_h == htotal - CW'(1)) |=> (cnt_h == '0));                       // R1
    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_h != htotal - CW'(1)) |=> (cnt_h == $past(cnt_h) + CW'(1)));    // R1
    AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_h != htotal - CW'(1)) |=> $stable(cnt_v));                      // R1
    AST_HBLANK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hblank) |-> (pix_x == hvis));                                  // R2
    AST_ACTIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (!hblank && !vblank));                                    // R6
    AST_FIELD_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_id) |-> (pix_x == '0 && line_y == '0));               // R7
    AST_OUT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (pix_x == $past(cnt_h) && line_y == $past(cnt_v)));        // R9

endmodule

bind raster_timing_gen rtg_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_h(cnt_h), .cnt_v(cnt_v), .htotal(live_htotal),
    .hvis(live_hvis), .pix_x(pix_x), .line_y(line_y), .hblank(hblank),
    .vblank(vblank), .active(active), .field_id(field_id)
);

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
// Cycle-by-cycle comparison of every output against an arithmetic model of
// the raster position and the shadow/live setting sets.
module raster_timing_gen_test;

    localparam int CW = 8;
    localparam int DW = 2 * CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          hsync, vsync, hblank, vblank, active, field_id;
    logic [CW-1:0] pix_x, line_y;

    always #2.5 clk = ~clk;

    raster_timing_gen #(
        .CW(CW), .DEF_HTOTAL(12), .DEF_HVIS(8), .DEF_VVIS(4), .DEF_HS_BEG(9),
        .DEF_HS_END(11), .DEF_LINES(7), .DEF_VBL_BEG(8), .DEF_VBL_END(9),
        .DEF_VS_LINE_BEG(5), .DEF_VS_LINE_END(6), .DEF_VS_PIX_BEG(2), .DEF_VS_PIX_END(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank), .active(active),
        .field_id(field_id), .pix_x(pix_x), .line_y(line_y)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // Model state: shadow and live words per address, counter position, outputs.
    logic [DW-1:0] sh [12];
    logic [DW-1:0] lv [12];
    int ch, cv, cf;
    int e_x, e_y, e_f, e_hb, e_hs, e_vb, e_vs, e_act;

    function automatic int lo(input logic [DW-1:0] w); return int'(w[CW-1:0]); endfunction
    function automatic int hi(input logic [DW-1:0] w); return int'(w[DW-1:CW]); endfunction
    function automatic logic [DW-1:0] pk(input int h, input int l);
        return {CW'(h), CW'(l)};
    endfunction

    task automatic model_reset();
        sh[0] = pk(0, 0);  sh[1] = pk(0, 12); sh[2] = pk(4, 8); sh[3] = pk(11, 9);
        for (int b = 0; b < 2; b++) begin
            sh[4+4*b] = pk(0, 7); sh[5+4*b] = pk(9, 8);
            sh[6+4*b] = pk(6, 5); sh[7+4*b] = pk(2, 2);
        end
        for (int a = 0; a < 12; a++) lv[a] = sh[a];
        ch = 0; cv = 0; cf = 0;
        e_x = 0; e_y = 0; e_f = 0; e_hb = 0; e_hs = 0; e_vb = 0; e_vs = 0; e_act = 0;
    endtask

    function automatic bit model_frame_end();
        int bs = 4 + 4 * cf;
        return (ch == lo(lv[1]) - 1) && (cv == lo(lv[bs]) - 1) && (lo(lv[0]) % 2 == 0 || cf == 1);
    endfunction

    // One clock edge of the model: outputs from the old position, then apply, advance, write.
    task automatic model_edge(input bit we, input logic [3:0] a, input logic [DW-1:0] d);
        int bs, key, nl;
        bit fe, il;
        bs  = 4 + 4 * cf;
        key = cv * 4096 + ch;
        e_x = ch; e_y = cv; e_f = cf;
        e_hb = (ch >= lo(lv[2]));
        e_hs = (ch >= lo(lv[3])) && (ch < hi(lv[3]));
        e_vb = (key >= hi(lv[2]) * 4096 + lo(lv[bs+1])) &&
               !((cv == lo(lv[bs]) - 1) && (ch >= hi(lv[bs+1])));
        e_vs = (key >= lo(lv[bs+2]) * 4096 + lo(lv[bs+3])) &&
               (key < hi(lv[bs+2]) * 4096 + hi(lv[bs+3]));
        e_act = !e_hb && !e_vb;
        fe = model_frame_end();
        il = lv[0][0];
        nl = lo(lv[bs]);
        if (ch == lo(lv[1]) - 1) begin
            ch = 0;
            if (cv == nl - 1) begin cv = 0; cf = il ? 1 - cf : 0; end
            else cv = cv + 1;
        end else ch = ch + 1;
        if (fe) for (int i = 0; i < 12; i++) lv[i] = sh[i];
        if (we && a < 12) sh[a] = d;
    endtask

    task automatic chk(input string req, input string nm, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at x=%0d y=%0d f=%0d: got %0d expected %0d",
                     req, nm, e_x, e_y, e_f, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1", "pix_x", int'(pix_x), e_x);
        chk("R1", "line_y", int'(line_y), e_y);
        chk("R7", "field_id", int'(field_id), e_f);
        chk("R2", "hblank", int'(hblank), e_hb);
        chk("R3", "hsync", int'(hsync), e_hs);
        chk("R4", "vblank", int'(vblank), e_vb);
        chk("R5", "vsync", int'(vsync), e_vs);
        chk("R6", "active", int'(active), e_act);
    endtask

    task automatic tick(input bit we, input logic [3:0] a, input logic [DW-1:0] d);
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_edge(we, a, d);
        @(negedge clk);
        wr_en = 1'b0;
        compare_all();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick(0, 4'd0, '0);
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        tick(1, 4'(a), d);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compare_all();                      // R9: reset state is all zero
        rst_n = 1'b1;
        run(200);                           // default progressive frames, R1..R6

        // R10 map, R8 shadowing: interlaced set written mid-frame
        wr(1, pk(0, 10));  wr(2, pk(3, 6));  wr(3, pk(9, 7));
        wr(4, pk(0, 6));   wr(5, pk(8, 6));  wr(6, pk(5, 4));  wr(7, pk(1, 3));
        wr(8, pk(0, 7));   wr(9, pk(7, 4));  wr(10, pk(5, 4)); wr(11, pk(8, 8));
        wr(13, pk(255, 255));               // unused address, ignored (R10)
        wr(0, pk(0, 1));                    // R7 interlace on
        run(400);

        // R8: write landing on the frame-end edge waits one more frame
        while (!model_frame_end()) tick(0, 4'd0, '0);
        wr(0, pk(0, 0));
        run(30);
        wr(1, pk(0, 9));  wr(2, pk(3, 5));  wr(3, pk(8, 6));
        wr(4, pk(0, 5));  wr(5, pk(6, 5));  wr(6, pk(4, 4));  wr(7, pk(7, 0));
        run(400);

        // R7/R8: interlace again, then change bank 1 during field 0
        wr(0, pk(0, 1));
        run(150);
        while (!(cf == 0 && cv == 1)) tick(0, 4'd0, '0);
        wr(8, pk(0, 8));
        run(400);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule